// File: doc/BRIEF.md
# Linked-List Descriptor Loader for One DMA Channel

This block is the list engine of one DMA channel. Software writes the address of the first node into the channel's next-node register and then sets the enable and list bits in the control word. The engine then reads each descriptor from memory into the channel's working registers. Each descriptor is an image of the channel register file. The engine runs the copy command that the descriptor describes, then follows the descriptor's next-node pointer. A zero pointer ends the list. A pointer back to an earlier node makes the list repeat until software cancels it.

Data movement is modelled only as a countdown of bytes, with the read and write addresses stepped per beat. The engine raises a loaded event once the first descriptor of a list is in place, and a done event for every command it completes. One channel's registers occupy a 0x40-byte window.

Top module: `lldma_chan`

## Requirements
- R1: After reset the control word (0x1C) reads 0, the remaining-size register (0x30) reads 0xFFFFFF, the event counter (0x18) reads 0, `mem_req_o` is low and no event is raised.
- R2: Writing the control word with bit 0 and bit 4 both set, while idle and with a nonzero next-node register, starts a fetch of eight 32-bit words from ascending addresses head+0 to head+28. Only one request is outstanding at a time, and `mem_addr_o` is held until `mem_rvalid_i` accepts the word.
- R3: Fetched words 0 to 5 replace the registers at offsets 0x00, 0x04, 0x08, 0x0C, 0x10 (low 24 bits) and 0x14. Words 6 and 7 are discarded.
- R4: A list start raises exactly one loaded event (`evt_o` with `evt_load_o`=1) when its first descriptor is complete, before any done event. Later nodes raise only done events (`evt_load_o`=0).
- R5: Size 0x10 holds the byte count minus one. A beat moves 2^min(config bits 2:0, config bits 6:4, log2 bus bytes) bytes. A command takes ceil(bytes/beat) cycles from the loaded/fetch-complete cycle to its done event. While the command runs, 0x30 reads the bytes remaining minus one.
- R6: 0x30 reads 0xFFFFFF whenever no command is running, including during descriptor fetch and after the last beat.
- R7: Config bit 8 makes the read address (0x08) advance by the beat size each beat, and bit 12 does the same for the write address (0x0C). With the bit clear, the address stays unchanged.
- R8: After a done event the engine fetches from the loaded next-node value if it is nonzero. If it is zero, the engine goes idle with control bits 0 and 4 cleared. A pointer back to an earlier node repeats the list without end.
- R9: Bits 5:0 of 0x18 count every event (loaded and done) modulo 64.
- R10: Writing the control word with bit 20 set puts the engine in idle at the next clock edge. After that edge `mem_req_o` is low, control reads 0, 0x30 reads 0xFFFFFF, and no further event occurs.
- R11: While a list is active, register writes other than a cancel have no effect.
- R12: A start request with a zero next-node register does nothing: there is no fetch, no event, and control reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from reg_addr_i) |
| mem_req_o | output | 1 | Descriptor read request, held until accepted |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_rvalid_i | input | 1 | Read data valid; accepts the current request |
| mem_rdata_i | input | 32 | Descriptor word |
| evt_o | output | 1 | One-cycle event pulse |
| evt_load_o | output | 1 | With evt_o: 1 = list loaded, 0 = command done |

## Verification
The main function is exercised on four list shapes: a single node, a two-node chain served by a slow memory, a node whose narrow read width forces one-byte beats with only the write address stepping, and a two-node circular list that runs past the counter wrap before it is cancelled. The single node and the narrow node differ in beat count and address stepping, which exposes errors in the width minimum and the increment selects. The chain separates next-pointer following from termination and from the loaded/done classification. The circular list shows wrap-around, counter modulo behaviour and the cancel cutoff. Writes issued in the middle of a command, and a start with a zero head, show that writes have no effect while the engine is busy and that a zero head is a no-op.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned WIDX_W     = $clog2(DESC_WORDS);

  localparam logic [5:0] OFF_GEN  = 6'h00;
  localparam logic [5:0] OFF_PORT = 6'h04;
  localparam logic [5:0] OFF_RD   = 6'h08;
  localparam logic [5:0] OFF_WR   = 6'h0C;
  localparam logic [5:0] OFF_SIZE = 6'h10;
  localparam logic [5:0] OFF_NEXT = 6'h14;
  localparam logic [5:0] OFF_CNT  = 6'h18;
  localparam logic [5:0] OFF_CTRL = 6'h1C;
  localparam logic [5:0] OFF_REM  = 6'h30;

  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_LIST   = 4;
  localparam int unsigned CTRL_CANCEL = 20;

  localparam int unsigned GEN_INC_RD = 8;
  localparam int unsigned GEN_INC_WR = 12;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/lldma_fetch.sv
module lldma_fetch
  import lldma_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic              cancel_i,
  input  logic              rvalid_i,
  output logic              req_o,
  output logic [AW-1:0]     addr_o,
  output logic              acc_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              last_o
);
  localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(DESC_WORDS - 1);

  logic              active_q;
  logic [WIDX_W-1:0] idx_q;
  logic [AW-1:0]     base_q;

  assign req_o  = active_q;
  assign addr_o = base_q + AW'({idx_q, 2'b00});
  assign acc_o  = active_q && rvalid_i && !cancel_i;
  assign widx_o = idx_q;
  assign last_o = acc_o && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
    end else if (cancel_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      base_q   <= base_i;
    end else if (acc_o) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lldma_count.sv
module lldma_count #(
  parameter int unsigned SIZE_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [SIZE_W-1:0] beat_i,
  input  logic              cancel_i,
  output logic [SIZE_W-1:0] rem_o,
  output logic              run_o,
  output logic              step_o,
  output logic              fin_o
);
  localparam logic [SIZE_W-1:0] IDLE_VAL = '1;

  logic [SIZE_W-1:0] rem_q;
  logic              run_q;

  assign rem_o  = rem_q;
  assign run_o  = run_q;
  assign step_o = run_q && !cancel_i;
  // remaining+1 <= beat  <=>  remaining < beat
  assign fin_o  = step_o && (rem_q < beat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= IDLE_VAL;
      run_q <= 1'b0;
    end else if (cancel_i) begin
      rem_q <= IDLE_VAL;
      run_q <= 1'b0;
    end else if (load_i) begin
      rem_q <= size_i;
      run_q <= 1'b1;
    end else if (fin_o) begin
      rem_q <= IDLE_VAL;
      run_q <= 1'b0;
    end else if (step_o) begin
      rem_q <= rem_q - beat_i;
    end
  end
endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned CH_AW     = 6,
  parameter int unsigned SIZE_W    = 24,
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned CNT_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [CH_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             evt_o,
  output logic             evt_load_o
);
  localparam int unsigned LOG_BUS = $clog2(BUS_BYTES);
  localparam logic [2:0]  LOG_BUS3 = 3'(LOG_BUS);

  eng_state_e state_q;

  logic [DW-1:0]     gen_q, port_q;
  logic [AW-1:0]     rd_q, wr_q, next_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q, lst_q, first_q;
  logic              evt_q, evt_load_q;

  logic              ctrl_wr, cancel, active, start, fetch_start;
  logic              f_acc, f_last;
  logic [WIDX_W-1:0] f_idx;
  logic [SIZE_W-1:0] rem_w, beat;
  logic              run_w, step_w, fin_w;
  logic [2:0]        lg_a, lg_ab;

  assign ctrl_wr = reg_we_i && (reg_addr_i == OFF_CTRL);
  assign cancel  = ctrl_wr && reg_wdata_i[CTRL_CANCEL];
  assign active  = (state_q != ST_IDLE);
  assign start   = ctrl_wr && !cancel && !active && reg_wdata_i[CTRL_EN] &&
                   reg_wdata_i[CTRL_LIST] && (next_q != '0);
  assign fetch_start = start || (fin_w && (next_q != '0));

  // beat size: narrowest of read width, write width, bus width
  assign lg_a  = (gen_q[2:0] < gen_q[6:4]) ? gen_q[2:0] : gen_q[6:4];
  assign lg_ab = (lg_a < LOG_BUS3) ? lg_a : LOG_BUS3;
  assign beat  = SIZE_W'(1) << lg_ab;

  lldma_fetch #(.AW(AW)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (fetch_start),
    .base_i   (next_q),
    .cancel_i (cancel),
    .rvalid_i (mem_rvalid_i),
    .req_o    (mem_req_o),
    .addr_o   (mem_addr_o),
    .acc_o    (f_acc),
    .widx_o   (f_idx),
    .last_o   (f_last)
  );

  lldma_count #(.SIZE_W(SIZE_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (f_last),
    .size_i   (size_q),
    .beat_i   (beat),
    .cancel_i (cancel),
    .rem_o    (rem_w),
    .run_o    (run_w),
    .step_o   (step_w),
    .fin_o    (fin_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else if (cancel) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start)  state_q <= ST_FETCH;
        ST_FETCH: if (f_last) state_q <= ST_RUN;
        ST_RUN:   if (fin_w)  state_q <= (next_q != '0) ? ST_FETCH : ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // working registers: software writes when idle, descriptor words when fetching
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q  <= '0;
      port_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      size_q <= '0;
      next_q <= '0;
    end else if (f_acc) begin
      unique case (f_idx)
        3'd0: gen_q  <= mem_rdata_i;
        3'd1: port_q <= mem_rdata_i;
        3'd2: rd_q   <= AW'(mem_rdata_i);
        3'd3: wr_q   <= AW'(mem_rdata_i);
        3'd4: size_q <= mem_rdata_i[SIZE_W-1:0];
        3'd5: next_q <= AW'(mem_rdata_i);
        default: ;
      endcase
    end else if (step_w) begin
      if (gen_q[GEN_INC_RD]) rd_q <= rd_q + AW'(beat);
      if (gen_q[GEN_INC_WR]) wr_q <= wr_q + AW'(beat);
    end else if (reg_we_i && !active) begin
      unique case (reg_addr_i)
        OFF_GEN:  gen_q  <= reg_wdata_i;
        OFF_PORT: port_q <= reg_wdata_i;
        OFF_RD:   rd_q   <= AW'(reg_wdata_i);
        OFF_WR:   wr_q   <= AW'(reg_wdata_i);
        OFF_SIZE: size_q <= reg_wdata_i[SIZE_W-1:0];
        OFF_NEXT: next_q <= AW'(reg_wdata_i);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      lst_q      <= 1'b0;
      first_q    <= 1'b0;
      evt_q      <= 1'b0;
      evt_load_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      evt_q      <= (f_last && first_q) || fin_w;
      evt_load_q <= f_last && first_q;
      if ((f_last && first_q) || fin_w) cnt_q <= cnt_q + 1'b1;
      if (cancel) begin
        en_q    <= 1'b0;
        lst_q   <= 1'b0;
        first_q <= 1'b0;
      end else if (start) begin
        en_q    <= 1'b1;
        lst_q   <= 1'b1;
        first_q <= 1'b1;
      end else begin
        if (f_last) first_q <= 1'b0;
        if (fin_w && (next_q == '0)) begin
          en_q  <= 1'b0;
          lst_q <= 1'b0;
        end
      end
    end
  end

  assign evt_o      = evt_q;
  assign evt_load_o = evt_load_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_GEN:  reg_rdata_o = gen_q;
      OFF_PORT: reg_rdata_o = port_q;
      OFF_RD:   reg_rdata_o = DW'(rd_q);
      OFF_WR:   reg_rdata_o = DW'(wr_q);
      OFF_SIZE: reg_rdata_o = DW'(size_q);
      OFF_NEXT: reg_rdata_o = DW'(next_q);
      OFF_CNT:  reg_rdata_o = DW'(cnt_q);
      OFF_CTRL: begin
        reg_rdata_o[CTRL_EN]   = en_q;
        reg_rdata_o[CTRL_LIST] = lst_q;
      end
      OFF_REM:  reg_rdata_o = DW'(rem_w);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lldma_chan_chk.sv
module lldma_chan_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned SIZE_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cancel_i,
  input logic              mem_req_i,
  input logic [AW-1:0]     mem_addr_i,
  input logic              mem_rvalid_i,
  input logic              evt_i,
  input logic              evt_load_i,
  input logic [SIZE_W-1:0] rem_i
);
  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_rvalid_i && !cancel_i) |=> (mem_req_i && $stable(mem_addr_i)));

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_rvalid_i && !cancel_i) |=>
      (!mem_req_i || (mem_addr_i == $past(mem_addr_i) + AW'(4))));

  // R4
  load_after_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && evt_load_i) |-> $past(mem_req_i && mem_rvalid_i));

  // R5
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !evt_load_i) |-> !$past(mem_req_i));

  // R6
  rem_idle_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> (rem_i == '1));

  // R10
  cancel_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> (!mem_req_i && !evt_i && (rem_i == '1)));
endmodule

bind lldma_chan lldma_chan_chk #(.AW(AW), .SIZE_W(SIZE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cancel_i     (cancel),
  .mem_req_i    (mem_req_o),
  .mem_addr_i   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .evt_i        (evt_o),
  .evt_load_i   (evt_load_o),
  .rem_i        (rem_w)
);

// File: tb/tb_lldma_chan.sv
`timescale 1ns/1ps
module tb_lldma_chan;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        evt_o, evt_load_o;

  always #2 clk = ~clk;

  lldma_chan dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .evt_o(evt_o), .evt_load_o(evt_load_o)
  );

  int checks = 0, fails = 0;
  int cyc = 0, mem_lat = 0, wcnt = 0;
  int ev_n = 0, fn = 0, exp_cnt = 0;
  logic [31:0] mem [0:63];
  logic        ev_kind [0:127];
  int          ev_cyc  [0:127];
  logic [31:0] f_log   [0:127];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // memory model and event monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (evt_o && ev_n < 128) begin
        ev_kind[ev_n] = evt_load_o;
        ev_cyc[ev_n]  = cyc;
      end
      if (evt_o) ev_n++;
      if (mem_req_o) begin
        if (wcnt >= mem_lat) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem[mem_addr_o[7:2]];
          if (fn < 128) f_log[fn] = mem_addr_o;
          fn++;
          wcnt = 0;
        end else begin
          mem_rvalid_i = 1'b0;
          wcnt++;
        end
      end else begin
        mem_rvalid_i = 1'b0;
        wcnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic put_node(input int base, input logic [31:0] gen, input logic [31:0] ra,
                          input logic [31:0] wa, input logic [31:0] sz, input logic [31:0] nx);
    mem[base/4+0] = gen;   mem[base/4+1] = 32'h5;
    mem[base/4+2] = ra;    mem[base/4+3] = wa;
    mem[base/4+4] = sz;    mem[base/4+5] = nx;
    mem[base/4+6] = 32'hDEAD_0006; mem[base/4+7] = 32'hBEEF_0007;
  endtask

  task automatic start_list(input logic [31:0] head);
    ev_n = 0; fn = 0;
    wr(6'h14, head);
    wr(6'h1C, 32'h11);
  endtask

  task automatic wait_ev(input string req, input int n);
    int t = 0;
    while (ev_n < n && t < 5000) begin @(negedge clk); t++; end
    chk(req, ev_n, n);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h1C, v); chk("R1 ctrl", v, 0);
    rd(6'h30, v); chk("R1 remaining", v, 32'hFFFFFF);
    rd(6'h18, v); chk("R1 counter", v, 0);
    chk("R1 mem_req", mem_req_o, 0);
    chk("R1 event", evt_o, 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    put_node(32'h40, 32'h1122, 32'h1000, 32'h2000, 15, 0);
    start_list(32'h40);
    wait_ev("R4 load seen", 1);
    rd(6'h30, v); chk("R5 remaining at start", v, 15);
    chk("R4 first kind", ev_kind[0], 1);
    wait_ev("R8 single done", 2);
    chk("R4 second kind", ev_kind[1], 0);
    chk("R5 beats 16B/4B", ev_cyc[1] - ev_cyc[0], 4);
    chk("R2 fetch count", fn, 8);
    for (int i = 0; i < 8; i++) chk("R2 fetch addr", f_log[i], 32'h40 + 4*i);
    rd(6'h00, v); chk("R3 gen cfg", v, 32'h1122);
    rd(6'h04, v); chk("R3 port cfg", v, 32'h5);
    rd(6'h10, v); chk("R3 size", v, 15);
    rd(6'h08, v); chk("R7 rd addr incr", v, 32'h1010);
    rd(6'h0C, v); chk("R7 wr addr incr", v, 32'h2010);
    rd(6'h30, v); chk("R6 drained", v, 32'hFFFFFF);
    rd(6'h1C, v); chk("R8 idle ctrl", v, 0);
    exp_cnt += 2;
    rd(6'h18, v); chk("R9 counter", v, exp_cnt % 64);
  endtask

  task automatic t_width;
    logic [31:0] v;
    put_node(32'h80, 32'h1020, 32'h3000, 32'h4000, 5, 0);
    start_list(32'h80);
    wait_ev("R5 narrow done", 2);
    chk("R4 narrow load", ev_kind[0], 1);
    chk("R5 beats 6B/1B", ev_cyc[1] - ev_cyc[0], 6);
    rd(6'h08, v); chk("R7 rd addr held", v, 32'h3000);
    rd(6'h0C, v); chk("R7 wr addr by 1", v, 32'h4006);
    exp_cnt += 2;
  endtask

  task automatic t_chain;
    logic [31:0] v;
    mem_lat = 2;
    put_node(32'h40, 32'h1122, 32'h1000, 32'h2000, 7, 32'h80);
    put_node(32'h80, 32'h1122, 32'h5000, 32'h6000, 3, 0);
    start_list(32'h40);
    wait_ev("R8 chain events", 3);
    chk("R4 chain kinds", {ev_kind[0], ev_kind[1], ev_kind[2]}, 3'b100);
    chk("R2 chain fetch count", fn, 16);
    for (int i = 0; i < 8; i++) chk("R8 second node addr", f_log[8+i], 32'h80 + 4*i);
    rd(6'h08, v); chk("R3 last node rd", v, 32'h5004);
    rd(6'h14, v); chk("R8 end pointer", v, 0);
    rd(6'h1C, v); chk("R8 chain idle", v, 0);
    mem_lat = 0;
    exp_cnt += 3;
  endtask

  task automatic t_ignore;
    logic [31:0] v;
    put_node(32'h40, 32'h1122, 32'h1000, 32'h2000, 63, 0);
    start_list(32'h40);
    wait_ev("R11 load", 1);
    wr(6'h00, 32'h0);
    wr(6'h14, 32'h1234);
    wr(6'h1C, 32'h0);
    rd(6'h1C, v); chk("R11 ctrl kept", v, 32'h11);
    wait_ev("R11 still completes", 2);
    rd(6'h00, v); chk("R11 gen kept", v, 32'h1122);
    rd(6'h14, v); chk("R11 next kept", v, 0);
    exp_cnt += 2;
  endtask

  task automatic t_zero_head;
    logic [31:0] v;
    start_list(32'h0);
    repeat (10) @(negedge clk);
    chk("R12 no event", ev_n, 0);
    chk("R12 no fetch", fn, 0);
    rd(6'h1C, v); chk("R12 ctrl", v, 0);
  endtask

  task automatic t_circular;
    logic [31:0] v;
    int n0, loads;
    put_node(32'h40, 32'h1122, 32'h1000, 32'h2000, 3, 32'hC0);
    put_node(32'hC0, 32'h1122, 32'h7000, 32'h8000, 3, 32'h40);
    start_list(32'h40);
    wait_ev("R8 circular runs", 67);
    wr(6'h1C, 32'h0010_0000);
    chk("R10 req low", mem_req_o, 0);
    rd(6'h1C, v); chk("R10 ctrl cleared", v, 0);
    rd(6'h30, v); chk("R10 remaining", v, 32'hFFFFFF);
    n0 = ev_n;
    repeat (20) @(negedge clk);
    chk("R10 no more events", ev_n, n0);
    chk("R10 req stays low", mem_req_o, 0);
    chk("R8 wrap to second", f_log[8], 32'hC0);
    chk("R8 wrap to head", f_log[16], 32'h40);
    loads = 0;
    for (int i = 0; i < 67; i++) loads += ev_kind[i];
    chk("R4 single load in loop", loads, 1);
    exp_cnt += n0;
    rd(6'h18, v); chk("R9 counter wrap", v, exp_cnt % 64);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_single;
    t_width;
    t_chain;
    t_ignore;
    t_zero_head;
    t_circular;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule